// File: doc/BRIEF.md
# Neighbour-Aware Memory Self-Test Sequencer

This controller tests a single-port memory of 256 words by 8 bits by itself, with no help from software beyond a start pulse. It drives the memory's address, write data and strobes, and takes the read data back in. It does not rely on a sweep that writes each word with its own address and reads it back, because such a sweep cannot expose a cell that is disturbed by its neighbours or a decoder that selects two rows at once.

Instead it steps a base address `b` from 0 to 254. At each base it treats word `b+1` as the victim and words `b` and `b+2` as its lower and upper neighbours, with all addresses wrapping modulo 256. It then runs a fixed program of 52 operations. The program checks each bit for stuck values, drives rising and falling neighbour transitions towards a victim that holds zeros and then towards one that holds ones, presents all four neighbour patterns while the victim is written, and checks that writing the neighbours leaves the victim untouched. A mismatch sets a sticky flag for its fault class and latches the address of the first failing read. After a coupling or decoder mismatch the victim is restored, so that the later checks at that base start from a known state.

Top module: `nbr_fault_bist`

## Requirements
- R1: A synchronous reset returns the block to idle: done, fail, all four class flags, fail_addr and both strobes are 0.
- R2: A start pulse while idle or done begins a new run at base 0 and clears the flags, fail and fail_addr. A start pulse during a run has no effect, so the run issues exactly the operations of an undisturbed run.
- R3: Read and write strobes are never high together. A write takes one cycle. A read takes two cycles: the strobe cycle, then a cycle with no strobe in which the returned data is compared.
- R4: Each base issues 33 writes and 19 reads, and bases 0 to 254 are visited, so a run on a fault-free memory issues 8415 writes and 4845 reads, ends with fail=0, all flags 0 and fail_addr=0, and holds done high with no strobes until the next start.
- R5: The stuck phase writes 8'h00 to word b and reads it, then writes 8'hFF and reads it. A mismatch sets flag_stuck.
- R6: The coupling phase clears the victim, then writes the lower neighbour 00 then FF, reads the victim, writes the lower neighbour 00, and reads again. It repeats these transitions on the upper neighbour. It then does the same with the victim preset to FF. Each read expects the preset value, and a mismatch sets flag_coup. A memory in which a rising bit 0 of word 127 sets bit 0 of word 128, and a rising bit 0 of word 129 clears it, yields only flag_coup with fail_addr=128 and 8417 writes.
- R7: The pattern phase sets (lower, upper) neighbours to (FF,00), (FF,FF), (00,FF) and (00,00), in that order. For each pattern it writes FF to the victim and reads it, then writes 00 and reads it. A mismatch sets flag_psf. A memory that blocks writes to each bit of word 128 whose bits in words 127 and 129 are both 1 yields only flag_psf, with fail_addr=128.
- R8: The decoder phase writes FF to the victim, 00 to both neighbours, then reads the victim expecting FF. A mismatch sets flag_dec. A memory whose address 128 also selects word 129, for writes and for a wired-OR read, yields flag_dec and flag_coup with fail_addr=128.
- R9: fail is 1 exactly when any class flag is 1. Flags, fail and fail_addr are sticky until the next start or reset. fail_addr holds the word address of the first mismatching read. A memory with bit 0 of word 128 stuck at 0 and bit 0 of word 129 stuck at 1 yields all four flags with fail_addr=128.
- R10: After a coupling mismatch the victim is rewritten with its expected value in one extra write. After a decoder mismatch, both neighbours are written 00 and then the victim is written FF, in three extra writes. Pattern and stuck mismatches add no writes. The decoder-fault memory of R8 therefore sees 8421 writes, and the memory of R7 sees 8415.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle run request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data returns the next cycle |
| mem_rdata | input | DW | Memory read data |
| done | output | 1 | Run complete, held until next start |
| fail | output | 1 | Any mismatch seen in this run |
| flag_stuck | output | 1 | Stuck-value mismatch seen |
| flag_coup | output | 1 | Neighbour-transition mismatch seen |
| flag_psf | output | 1 | Neighbour-pattern mismatch seen |
| flag_dec | output | 1 | Aliased-write mismatch seen |
| fail_addr | output | AW | Address of the first mismatching read |

## Verification
The hardest state to reach is a mismatch in the middle of a base, followed by the restore writes and the resumption of the program. Only a memory that actually misbehaves at one place can produce it. The bench therefore attaches a memory model that can hold one of four faults around words 127 to 129. It derives the expected flags, first address and write count of each fault by tracing the program against that fault, so a missing or extra restore write shows up in the transaction counts. A start pulse in the middle of a run and a reset in the middle of a failing run exercise the ignore and clear paths.

// File: rtl/nbr_fault_bist.sv
module nbr_fault_bist #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          fail,
  output logic          flag_stuck,
  output logic          flag_coup,
  output logic          flag_psf,
  output logic          flag_dec,
  output logic [AW-1:0] fail_addr
);

  localparam int NSTEP = 52;
  localparam int SW = $clog2(NSTEP);
  localparam int PAT0 = 24;
  localparam int DEC0 = 48;
  localparam logic [AW-1:0] LASTB = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [1:0] TL = 2'd0, TV = 2'd1, TH = 2'd2;
  localparam logic [1:0] C_STK = 2'd0, C_CPL = 2'd1, C_PAT = 2'd2, C_DEC = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_OP, S_CMP, S_FIX, S_DONE} st_t;

  st_t           state;
  logic [AW-1:0] base;
  logic [SW-1:0] step;
  logic [1:0]    fixn;
  logic [3:0]    flags;
  logic          fail_q;

  function automatic logic [5:0] op(input logic rd, input logic [1:0] t,
                                    input logic one, input logic [1:0] c);
    return {rd, t, one, c};
  endfunction

  logic [5:0] sd;
  always_comb begin
    int pi;
    int k;
    pi = int'(step) - PAT0;
    k  = pi / 6;
    sd = op(1'b0, TL, 1'b0, C_STK);
    if (int'(step) >= PAT0 && int'(step) < DEC0) begin
      case (pi % 6)
        0:       sd = op(1'b0, TL, k < 2, C_PAT);
        1:       sd = op(1'b0, TH, k == 1 || k == 2, C_PAT);
        2:       sd = op(1'b0, TV, 1'b1, C_PAT);
        3:       sd = op(1'b1, TV, 1'b1, C_PAT);
        4:       sd = op(1'b0, TV, 1'b0, C_PAT);
        default: sd = op(1'b1, TV, 1'b0, C_PAT);
      endcase
    end else begin
      case (int'(step))
        0:  sd = op(1'b0, TL, 1'b0, C_STK);
        1:  sd = op(1'b1, TL, 1'b0, C_STK);
        2:  sd = op(1'b0, TL, 1'b1, C_STK);
        3:  sd = op(1'b1, TL, 1'b1, C_STK);
        4:  sd = op(1'b0, TV, 1'b0, C_CPL);
        5:  sd = op(1'b0, TL, 1'b0, C_CPL);
        6:  sd = op(1'b0, TL, 1'b1, C_CPL);
        7:  sd = op(1'b1, TV, 1'b0, C_CPL);
        8:  sd = op(1'b0, TL, 1'b0, C_CPL);
        9:  sd = op(1'b1, TV, 1'b0, C_CPL);
        10: sd = op(1'b0, TH, 1'b1, C_CPL);
        11: sd = op(1'b1, TV, 1'b0, C_CPL);
        12: sd = op(1'b0, TH, 1'b0, C_CPL);
        13: sd = op(1'b1, TV, 1'b0, C_CPL);
        14: sd = op(1'b0, TV, 1'b1, C_CPL);
        15: sd = op(1'b0, TL, 1'b1, C_CPL);
        16: sd = op(1'b1, TV, 1'b1, C_CPL);
        17: sd = op(1'b0, TL, 1'b0, C_CPL);
        18: sd = op(1'b1, TV, 1'b1, C_CPL);
        19: sd = op(1'b0, TH, 1'b1, C_CPL);
        20: sd = op(1'b1, TV, 1'b1, C_CPL);
        21: sd = op(1'b0, TH, 1'b0, C_CPL);
        22: sd = op(1'b1, TV, 1'b1, C_CPL);
        23: sd = op(1'b0, TV, 1'b0, C_PAT);
        48: sd = op(1'b0, TV, 1'b1, C_DEC);
        49: sd = op(1'b0, TL, 1'b0, C_DEC);
        50: sd = op(1'b0, TH, 1'b0, C_DEC);
        default: sd = op(1'b1, TV, 1'b1, C_DEC);
      endcase
    end
  end

  wire        s_rd  = sd[5];
  wire [1:0]  s_tgt = sd[4:3];
  wire        s_one = sd[2];
  wire [1:0]  s_cls = sd[1:0];

  function automatic logic [AW-1:0] taddr(input logic [AW-1:0] b, input logic [1:0] t);
    return b + AW'(t);
  endfunction

  wire [AW-1:0] op_addr  = taddr(base, s_tgt);
  wire          fix_dec  = (s_cls == C_DEC);
  wire          fix_nbr  = fix_dec && (fixn != 2'd2);
  wire [AW-1:0] fix_addr = fix_nbr ? taddr(base, (fixn == 2'd0) ? TL : TH) : taddr(base, TV);
  wire          fix_last = !fix_dec || (fixn == 2'd2);
  wire          mism     = (mem_rdata != {DW{s_one}});
  wire          need_fix = (s_cls == C_CPL) || fix_dec;

  wire          last_step = (int'(step) == NSTEP - 1);
  wire          last_base = (base == LASTB);
  wire st_t     adv_state = (last_step && last_base) ? S_DONE : S_OP;
  wire [SW-1:0] adv_step  = last_step ? '0 : step + 1'b1;
  wire [AW-1:0] adv_base  = last_step ? base + 1'b1 : base;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      base      <= '0;
      step      <= '0;
      fixn      <= '0;
      flags     <= '0;
      fail_q    <= 1'b0;
      fail_addr <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          state     <= S_OP;
          base      <= '0;
          step      <= '0;
          flags     <= '0;
          fail_q    <= 1'b0;
          fail_addr <= '0;
        end
        S_OP: if (s_rd) state <= S_CMP;
              else begin state <= adv_state; step <= adv_step; base <= adv_base; end
        S_CMP: begin
          if (mism) begin
            flags[s_cls] <= 1'b1;
            fail_q <= 1'b1;
            if (!fail_q) fail_addr <= op_addr;
          end
          if (mism && need_fix) begin
            state <= S_FIX;
            fixn  <= '0;
          end else begin
            state <= adv_state; step <= adv_step; base <= adv_base;
          end
        end
        S_FIX: if (fix_last) begin state <= adv_state; step <= adv_step; base <= adv_base; end
               else fixn <= fixn + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_we     = (state == S_OP && !s_rd) || state == S_FIX;
  assign mem_re     = (state == S_OP) && s_rd;
  assign mem_addr   = (state == S_FIX) ? fix_addr : op_addr;
  assign mem_wdata  = (state == S_FIX && fix_nbr) ? '0 : {DW{s_one}};
  assign done       = (state == S_DONE);
  assign fail       = fail_q;
  assign flag_stuck = flags[C_STK];
  assign flag_coup  = flags[C_CPL];
  assign flag_psf   = flags[C_PAT];
  assign flag_dec   = flags[C_DEC];

endmodule

module nbr_fault_bist_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mem_we,
  input logic          mem_re,
  input logic          done,
  input logic          fail,
  input logic [3:0]    flags,
  input logic [AW-1:0] fail_addr
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !fail && flags == 4'd0 && fail_addr == '0 && !mem_we && !mem_re));

  p_done_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_re));

  p_excl_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_read_gap_r3: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && !mem_we));

  p_fail_match_r9: assert property (@(posedge clk) disable iff (rst)
    fail == (|flags));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && done)) |=> (fail && $stable(fail_addr)));

  p_fail_after_read_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(mem_re, 2));

endmodule

bind nbr_fault_bist nbr_fault_bist_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_we(mem_we), .mem_re(mem_re),
  .done(done), .fail(fail),
  .flags({flag_dec, flag_psf, flag_coup, flag_stuck}),
  .fail_addr(fail_addr)
);

// File: tb/nbr_fault_bist_bench.sv
`timescale 1ns/1ps
module nbr_fault_bist_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we, mem_re, done, fail;
  logic flag_stuck, flag_coup, flag_psf, flag_dec;
  logic [7:0] fail_addr;

  always #2.5 clk = ~clk;

  nbr_fault_bist u_nbr_fault_bist (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .fail(fail),
    .flag_stuck(flag_stuck), .flag_coup(flag_coup), .flag_psf(flag_psf), .flag_dec(flag_dec),
    .fail_addr(fail_addr)
  );

  // fault modes: 0 none, 1 stuck bits, 2 coupling, 3 pattern, 4 aliased decoder
  int fmode = 0;
  logic clr = 1'b0;
  logic [7:0] mem [256];
  int wcnt, rcnt;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem_rdata <= 8'h00;
      wcnt = 0;
      rcnt = 0;
    end else if (mem_re) begin
      logic [7:0] v;
      rcnt++;
      v = mem[mem_addr];
      if (fmode == 1 && mem_addr == 8'd129) v[0] = 1'b1;
      if (fmode == 1 && mem_addr == 8'd128) v[0] = 1'b0;
      if (fmode == 4 && mem_addr == 8'd128) v = v | mem[129];
      mem_rdata <= v;
    end else if (mem_we) begin
      wcnt++;
      if (fmode == 3 && mem_addr == 8'd128) begin
        for (int j = 0; j < 8; j++)
          if (!(mem[129][j] && mem[127][j])) mem[128][j] = mem_wdata[j];
      end else begin
        if (fmode == 2 && mem_addr == 8'd127 && !mem[127][0] && mem_wdata[0]) mem[128][0] = 1'b1;
        if (fmode == 2 && mem_addr == 8'd129 && !mem[129][0] && mem_wdata[0]) mem[128][0] = 1'b0;
        mem[mem_addr] = mem_wdata;
        if (fmode == 4 && mem_addr == 8'd128) mem[129] = mem_wdata;
      end
    end
  end

  int nchk = 0, nerr = 0;
  int runs_done = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct {
    string      name;
    logic [3:0] flags;   // {dec, psf, coup, stuck}
    logic [7:0] addr;
    int         wr;      // -1: not checked
    int         rd;
  } exp_t;

  exp_t q[$];

  function automatic logic [3:0] flv();
    return {flag_dec, flag_psf, flag_coup, flag_stuck};
  endfunction

  initial begin
    forever begin
      exp_t e;
      @(posedge done);
      #1;
      if (q.size() == 0) begin
        chk("R2 unexpected completion", 1, 0);
      end else begin
        e = q.pop_front();
        chk({e.name, " R9 fail"}, fail, e.flags != 4'd0);
        chk({e.name, " R9 flags"}, flv(), e.flags);
        chk({e.name, " R9 fail_addr"}, fail_addr, e.addr);
        chk({e.name, " R4 reads"}, rcnt, e.rd);
        if (e.wr >= 0) chk({e.name, " R10 writes"}, wcnt, e.wr);
      end
      runs_done++;
    end
  end

  task automatic run(input string name, input int mode, input logic [3:0] fl,
                     input logic [7:0] ad, input int wr, input bit mid_start);
    exp_t e;
    int target;
    @(negedge clk);
    fmode = mode;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    e.name = name; e.flags = fl; e.addr = ad; e.wr = wr; e.rd = 4845;
    q.push_back(e);
    target = runs_done + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (5000) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (runs_done == target);
    repeat (10) @(negedge clk);
    chk({name, " R4 done held"}, done, 1);
    chk({name, " R4 quiet after done"}, mem_we | mem_re, 0);
  endtask

  task automatic idle_checks(input string tag);
    chk({tag, " R1 done"}, done, 0);
    chk({tag, " R1 fail"}, fail, 0);
    chk({tag, " R1 flags"}, flv(), 0);
    chk({tag, " R1 fail_addr"}, fail_addr, 0);
    chk({tag, " R1 strobes"}, mem_we | mem_re, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_checks("reset");

    // R2: a start pulse mid-run must not restart the walk (counts stay exact)
    run("clean R2", 0, 4'b0000, 8'd0, 8415, 1'b1);

    // R1/R9: reset during a failing run clears the sticky state
    @(negedge clk);
    fmode = 1;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12000) @(negedge clk);
    chk("abort R9 fail latched before reset", fail, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_checks("mid-run reset");

    run("stuck R5", 1, 4'b1111, 8'd128, -1, 1'b0);
    run("coupling R6", 2, 4'b0010, 8'd128, 8417, 1'b0);
    run("pattern R7", 3, 4'b0100, 8'd128, 8415, 1'b0);
    run("decoder R8", 4, 4'b1010, 8'd128, 8421, 1'b0);
    run("clean again R9", 0, 4'b0000, 8'd0, 8415, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule